// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the memory and register side effects of subroutine entry and exit for a processor with nine general registers, where the last register (index 8) is the frame pointer. A call request carries the target PC, the frame size and whether the calling instruction carries an immediate. The block derives the new frame pointer as the current frame pointer plus the frame size. It stores the return PC and the caller's frame pointer in the two words just below the new frame. It then writes the new frame pointer into register 8 and redirects the PC.

A return request reads those two words back. The frame pointer goes back to the caller's value, which releases the callee's stack space, and the PC is loaded from the saved return address. By the calling convention, the first three arguments travel in r1 to r3 and the result comes back in r0. Stack arguments from the fourth onward sit at descending addresses and locals at ascending addresses. The block itself only maintains the two linkage words and the frame pointer.

The block drives a single-port synchronous data memory, whose read data arrives one cycle after the read is issued. It also drives one register-file write port. The current frame pointer is read in from the register file.

Top module: `callret_seq`

## Requirements
- R1: After reset, busy, memEn, memWe, rfWe and pcLoad are all low.
- R2: In the first cycle after a call is accepted, the block writes the return PC to address (fpIn + frameSize) − 1.
- R3: The saved return PC is curPc + 1 when hasImm is 0, and curPc + 2 when hasImm is 1.
- R4: In the second cycle after a call is accepted, the block writes the caller's frame pointer (fpIn at acceptance) to address newFp − 2.
- R5: In that same second cycle, the call commits: rfWe is high with rfWaddr = 8 and rfWdata = newFp, and pcLoad is high with pcNext = callTarget. The commit strobes are never high in any other cycle of a call.
- R6: A return reads address fp − 1 in the first cycle after acceptance and fp − 2 in the second, with memWe low, where fp is fpIn at acceptance.
- R7: A return commits only in the third cycle after acceptance: rfWe is high with rfWaddr = 8 and rfWdata = the word read from fp − 2, and pcLoad is high with pcNext = the word read from fp − 1.
- R8: busy is high for exactly the cycles of a sequence: 2 for a call, 3 for a return. Call or return requests that arrive while busy start nothing.
- R9: When callReq and retReq are both high while idle, the call is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Start a call sequence (sampled while idle) |
| retReq | input | 1 | Start a return sequence (sampled while idle) |
| curPc | input | WIDTH | Address of the call instruction |
| hasImm | input | 1 | Call instruction carries an immediate word |
| callTarget | input | WIDTH | Entry PC of the callee |
| frameSize | input | WIDTH | Offset from the caller fp to the callee fp |
| fpIn | input | WIDTH | Current value of register 8 |
| busy | output | 1 | Sequence in progress |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write (low means read) |
| memAddr | output | WIDTH | Memory word address |
| memWdata | output | WIDTH | Memory write data |
| memRdata | input | WIDTH | Memory read data, one cycle after the read |
| rfWe | output | 1 | Register-file write enable |
| rfWaddr | output | 4 | Register-file write index (always 8) |
| rfWdata | output | WIDTH | Register-file write data |
| pcLoad | output | 1 | Load pcNext into the PC |
| pcNext | output | WIDTH | New PC value |

## Verification
A request is presented before clock edge E0, and every later result is sampled at the falling edge that follows the relevant rising edge. For a call, the return-PC write is due after E0, the caller-fp write and the commit after E1, and idle after E2. For a return, the reads are due after E0 and E1, the commit after E2 (using data the memory model returned for those reads), and idle after E3. Each directed task waits for the exact number of falling edges before it samples. It then re-reads the bench's memory and frame-pointer models one cycle after the commit, so that both the port values and their effect are confirmed.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALL_W1,
    ST_CALL_W2,
    ST_RET_R1,
    ST_RET_R2,
    ST_RET_DONE
  } seqState_t;

  typedef struct packed {
    logic latchCall;
    logic latchRet;
    logic memAccess;
    logic memWrite;
    logic slotB;
    logic capRet;
    logic commit;
  } seqCtrl_t;

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     callReq,
  input  logic     retReq,
  output seqCtrl_t ctl,
  output logic     busy
);

  seqState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    ctl      = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (callReq) begin
          ctl.latchCall = 1'b1;
          nxtState      = ST_CALL_W1;
        end else if (retReq) begin
          ctl.latchRet = 1'b1;
          nxtState     = ST_RET_R1;
        end
      end
      ST_CALL_W1: begin
        ctl.memAccess = 1'b1;
        ctl.memWrite  = 1'b1;
        nxtState      = ST_CALL_W2;
      end
      ST_CALL_W2: begin
        ctl.memAccess = 1'b1;
        ctl.memWrite  = 1'b1;
        ctl.slotB     = 1'b1;
        ctl.commit    = 1'b1;
        nxtState      = ST_IDLE;
      end
      ST_RET_R1: begin
        ctl.memAccess = 1'b1;
        nxtState      = ST_RET_R2;
      end
      ST_RET_R2: begin
        ctl.memAccess = 1'b1;
        ctl.slotB     = 1'b1;
        ctl.capRet    = 1'b1;
        nxtState      = ST_RET_DONE;
      end
      ST_RET_DONE: begin
        ctl.commit = 1'b1;
        nxtState   = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
  import callret_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         ctl,
  input  logic [WIDTH-1:0] curPc,
  input  logic             hasImm,
  input  logic [WIDTH-1:0] callTarget,
  input  logic [WIDTH-1:0] frameSize,
  input  logic [WIDTH-1:0] fpIn,
  input  logic [WIDTH-1:0] memRdata,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] memWdata,
  output logic [WIDTH-1:0] rfWdata,
  output logic [WIDTH-1:0] pcNext
);

  logic [WIDTH-1:0] frameBase;
  logic [WIDTH-1:0] slotA;
  logic [WIDTH-1:0] slotBVal;
  logic [WIDTH-1:0] targetReg;
  logic             isRet;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameBase <= '0;
      slotA     <= '0;
      slotBVal  <= '0;
      targetReg <= '0;
      isRet     <= 1'b0;
    end else begin
      if (ctl.latchCall) begin
        frameBase <= fpIn + frameSize;
        slotA     <= curPc + (hasImm ? WIDTH'(2) : WIDTH'(1));
        slotBVal  <= fpIn;
        targetReg <= callTarget;
        isRet     <= 1'b0;
      end
      if (ctl.latchRet) begin
        frameBase <= fpIn;
        isRet     <= 1'b1;
      end
      if (ctl.capRet) slotA <= memRdata;
    end
  end

  assign memAddr  = frameBase - (ctl.slotB ? WIDTH'(2) : WIDTH'(1));
  assign memWdata = ctl.slotB ? slotBVal : slotA;
  assign rfWdata  = isRet ? memRdata : frameBase;
  assign pcNext   = isRet ? slotA : targetReg;

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int NUM_REGS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callReq,
  input  logic             retReq,
  input  logic [WIDTH-1:0] curPc,
  input  logic             hasImm,
  input  logic [WIDTH-1:0] callTarget,
  input  logic [WIDTH-1:0] frameSize,
  input  logic [WIDTH-1:0] fpIn,
  output logic             busy,
  output logic             memEn,
  output logic             memWe,
  output logic [WIDTH-1:0] memAddr,
  output logic [WIDTH-1:0] memWdata,
  input  logic [WIDTH-1:0] memRdata,
  output logic             rfWe,
  output logic [3:0]       rfWaddr,
  output logic [WIDTH-1:0] rfWdata,
  output logic             pcLoad,
  output logic [WIDTH-1:0] pcNext
);

  localparam int FP_INDEX = NUM_REGS - 1;

  seqCtrl_t ctl;

  callret_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .callReq (callReq),
    .retReq  (retReq),
    .ctl     (ctl),
    .busy    (busy)
  );

  callret_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .curPc      (curPc),
    .hasImm     (hasImm),
    .callTarget (callTarget),
    .frameSize  (frameSize),
    .fpIn       (fpIn),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .rfWdata    (rfWdata),
    .pcNext     (pcNext)
  );

  assign memEn   = ctl.memAccess;
  assign memWe   = ctl.memWrite;
  assign rfWe    = ctl.commit;
  assign pcLoad  = ctl.commit;
  assign rfWaddr = 4'(FP_INDEX);

endmodule

// File: rtl/callret_checks.sv
module callret_checks #(
  parameter int WIDTH    = 32,
  parameter int NUM_REGS = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             callReq,
  input logic             busy,
  input logic             memEn,
  input logic             memWe,
  input logic [WIDTH-1:0] memAddr,
  input logic             rfWe,
  input logic [3:0]       rfWaddr,
  input logic             pcLoad
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memEn && !rfWe && !pcLoad)) else $error("idle strobes"); // R1

  AST_START_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> memEn) else $error("start without access"); // R2

  AST_SECOND_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && $past(memEn && memWe)) |-> memAddr == $past(memAddr) - WIDTH'(1))
    else $error("second write slot"); // R4

  AST_COMMIT_FP: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (busy && rfWe && rfWaddr == 4'(NUM_REGS - 1))) else $error("commit target"); // R5

  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe && $past(memEn && !memWe)) |-> memAddr == $past(memAddr) - WIDTH'(1))
    else $error("read order"); // R6

  AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !busy) else $error("commit not last"); // R8

  AST_CALL_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && callReq) |=> (memEn && memWe)) else $error("call priority"); // R9

endmodule

bind callret_seq callret_checks #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS)) u_checks (.*);

// File: tb/test_callret_seq.sv
module test_callret_seq;

  localparam int  WIDTH     = 32;
  localparam time CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             callReq = 1'b0;
  logic             retReq = 1'b0;
  logic [WIDTH-1:0] curPc = '0;
  logic             hasImm = 1'b0;
  logic [WIDTH-1:0] callTarget = '0;
  logic [WIDTH-1:0] frameSize = '0;
  logic [WIDTH-1:0] fpReg = 32'd100;
  logic             busy, memEn, memWe, rfWe, pcLoad;
  logic [WIDTH-1:0] memAddr, memWdata, memRdata, rfWdata, pcNext;
  logic [3:0]       rfWaddr;

  logic [WIDTH-1:0] mem [0:255];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  callret_seq i_callret_seq (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .curPc(curPc), .hasImm(hasImm), .callTarget(callTarget),
    .frameSize(frameSize), .fpIn(fpReg), .busy(busy), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .rfWe(rfWe), .rfWaddr(rfWaddr),
    .rfWdata(rfWdata), .pcLoad(pcLoad), .pcNext(pcNext)
  );

  // Memory model: synchronous, read data one cycle later
  always @(posedge clk) begin
    if (memEn && memWe) mem[memAddr[7:0]] <= memWdata;
    if (memEn && !memWe) memRdata <= mem[memAddr[7:0]];
  end

  // Register 8 model
  always @(posedge clk) begin
    if (rfWe && rfWaddr == 4'd8) fpReg <= rfWdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doCall(input logic [WIDTH-1:0] pc, input bit imm,
                        input logic [WIDTH-1:0] size, input logic [WIDTH-1:0] tgt);
    logic [WIDTH-1:0] oldFp, newFp, retPc;
    @(negedge clk);
    oldFp = fpReg;
    newFp = fpReg + size;
    retPc = pc + (imm ? 2 : 1);
    curPc = pc; hasImm = imm; frameSize = size; callTarget = tgt; callReq = 1'b1;
    @(negedge clk);
    callReq = 1'b0;
    chk(busy && memEn && memWe, "R2", "first write strobes", {memWe, memEn, busy}, 7);
    chk(memAddr == newFp - 1, "R2", "return pc slot addr", memAddr, newFp - 1);
    chk(memWdata == retPc, "R3", "saved return pc", memWdata, retPc);
    chk(!pcLoad && !rfWe, "R5", "no early commit", {rfWe, pcLoad}, 0);
    @(negedge clk);
    chk(memEn && memWe && memAddr == newFp - 2, "R4", "caller fp slot addr", memAddr, newFp - 2);
    chk(memWdata == oldFp, "R4", "saved caller fp", memWdata, oldFp);
    chk(rfWe && rfWaddr == 4'd8 && rfWdata == newFp, "R5", "fp write", rfWdata, newFp);
    chk(pcLoad && pcNext == tgt, "R5", "pc redirect", pcNext, tgt);
    @(negedge clk);
    chk(!busy, "R8", "busy drops after call", busy, 0);
    chk(mem[8'(newFp - 1)] == retPc, "R2", "mem return pc", mem[8'(newFp - 1)], retPc);
    chk(mem[8'(newFp - 2)] == oldFp, "R4", "mem caller fp", mem[8'(newFp - 2)], oldFp);
    chk(fpReg == newFp, "R5", "r8 updated", fpReg, newFp);
  endtask

  task automatic doRet(input logic [WIDTH-1:0] expPc, input logic [WIDTH-1:0] expFp);
    logic [WIDTH-1:0] fp;
    @(negedge clk);
    fp = fpReg;
    retReq = 1'b1;
    @(negedge clk);
    retReq = 1'b0;
    chk(busy && memEn && !memWe && memAddr == fp - 1, "R6", "first read fp-1", memAddr, fp - 1);
    chk(!rfWe && !pcLoad, "R7", "no commit in read 1", {rfWe, pcLoad}, 0);
    @(negedge clk);
    chk(memEn && !memWe && memAddr == fp - 2, "R6", "second read fp-2", memAddr, fp - 2);
    chk(!rfWe && !pcLoad, "R7", "no commit in read 2", {rfWe, pcLoad}, 0);
    @(negedge clk);
    chk(busy && !memEn, "R8", "third cycle busy no access", {busy, memEn}, 2);
    chk(rfWe && rfWaddr == 4'd8 && rfWdata == expFp, "R7", "fp restore", rfWdata, expFp);
    chk(pcLoad && pcNext == expPc, "R7", "pc restore", pcNext, expPc);
    @(negedge clk);
    chk(!busy, "R8", "busy drops after ret", busy, 0);
    chk(fpReg == expFp, "R7", "r8 restored", fpReg, expFp);
  endtask

  task automatic testResetState();
    chk(!busy && !memEn && !memWe && !rfWe && !pcLoad, "R1", "reset outputs",
        {busy, memEn, memWe, rfWe, pcLoad}, 0);
  endtask

  task automatic testPriorityAndIgnore();
    logic [WIDTH-1:0] oldFp;
    @(negedge clk);
    oldFp = fpReg;
    curPc = 32'd70; hasImm = 1'b0; frameSize = 32'd6; callTarget = 32'd90;
    callReq = 1'b1; retReq = 1'b1;
    @(negedge clk);
    chk(memEn && memWe, "R9", "call wins over ret", {memEn, memWe}, 3);
    chk(memAddr == oldFp + 6 - 1, "R9", "call slot addr", memAddr, oldFp + 5);
    @(negedge clk);
    chk(pcLoad && pcNext == 32'd90, "R8", "sequence unaffected", pcNext, 90);
    callReq = 1'b0; retReq = 1'b0;
    @(negedge clk);
    chk(!busy && !memEn, "R8", "held requests ignored while busy", {busy, memEn}, 0);
    @(negedge clk);
    chk(!busy && fpReg == oldFp + 6, "R8", "no extra sequence", fpReg, oldFp + 6);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    memRdata = '0;
    repeat (3) @(negedge clk);
    testResetState();
    rstN = 1'b1;
    @(negedge clk);
    testResetState();
    doCall(32'd10, 1'b0, 32'd8, 32'd50);   // fp 100 -> 108, ret 11
    doCall(32'd51, 1'b1, 32'd4, 32'd200);  // fp 108 -> 112, ret 53
    doRet(32'd53, 32'd108);
    doRet(32'd11, 32'd100);
    testPriorityAndIgnore();               // fp 100 -> 106
    doRet(32'd71, 32'd100);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule